// File: doc/BRIEF.md
# Video Memory Write and Block-Copy Engine

This block sits between a 32-bit processor write bus and a video memory of 32-bit words. Each bus write carries a 2-bit aperture code that picks one of four operations. A masked store skips every byte that is zero, so the old pixel shows through. A four-word group fill writes a preset colour word into selected bytes of an aligned group. A source-pointer store holds a word address for later use. A block copy moves a fixed run of words from that pointer to the written address.

Group fills and block copies take several cycles. While one runs, the engine raises `stall`. The bus master must hold off, because any write offered during that time is dropped. A separate strobe loads the fill colour register.

Memory addresses are word addresses `AW` bits wide. A byte address of four times the bus offset, wrapped at the memory size, is the same as the offset taken modulo 2^AW. All address arithmetic wraps inside the memory. The memory has a synchronous read with one cycle of latency.

Top module: `vram_blit_engine`

## Requirements
- R1: A write with `bus_sel`=0 and `stall` low stores `bus_data` at word `bus_off` in the same cycle. A byte lane j (bits 8j+7:8j) is written only when `bus_be[j]` is 1 and that data byte is non-zero. When no lane qualifies, no memory write is issued.
- R2: A write with `bus_sel`=1 and `stall` low targets the four words starting at `bus_off` with its two low bits cleared.
- R3: For the group fill, the mask is `bus_data` ANDed with the bus byte mask and with 0x0F0F0F0F. Bits 8k+3:8k of the mask are the lane enables of word k of the group, where bit j enables lane j. Word k gets the fill colour in its enabled lanes, and words with no enabled lane are left alone. The mask 0x0F0F0F0F writes the whole colour into all four words.
- R4: A `fill_wr` pulse while `stall` is low loads `fill_data` into the fill colour register. The value then holds until the next load.
- R5: A write with `bus_sel`=2 and `stall` low stores `bus_off` as the copy source pointer and causes no memory access.
- R6: A write with `bus_sel`=3 and `stall` low copies `COPY_WORDS` words. Word i moves from source pointer + i to `bus_off` + i, both modulo 2^AW. The words move in increasing i, one word fully before the next, so overlapping ranges behave as a sequential copy.
- R7: A copy holds `stall` high for exactly 2×`COPY_WORDS` cycles, alternating one read cycle and one write cycle. Reads and writes never occur in the same cycle.
- R8: A group fill holds `stall` high for exactly 4 cycles.
- R9: While `stall` is high, `bus_wr` and `fill_wr` are ignored. Memory, the fill colour and the source pointer are all left unchanged.
- R10: After reset, `stall` is low, no memory access is issued, and both the fill colour and the source pointer are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_sel | input | 2 | Aperture: 0 masked store, 1 group fill, 2 source pointer, 3 block copy |
| bus_off | input | AW | Word offset of the bus write |
| bus_data | input | 32 | Bus write data |
| bus_be | input | 4 | Bus byte-lane mask |
| fill_wr | input | 1 | Fill colour load strobe |
| fill_data | input | 32 | Fill colour value |
| stall | output | 1 | Engine busy; bus writes are dropped |
| mem_addr | output | AW | Memory word address |
| mem_re | output | 1 | Memory read request |
| mem_we | output | 1 | Memory write request |
| mem_be | output | 4 | Memory byte-lane write enables |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid one cycle after `mem_re` |

## Verification
The masked store is tried with every combination of zero data bytes against every bus byte mask. A wrong lane condition therefore shows as a specific missed or extra byte. Group fills are swept over unaligned offsets, over per-word nibble patterns with junk in the upper nibbles, and over partial bus masks. This separates alignment errors, nibble-to-word mapping errors and bus-mask handling. Copies are run with disjoint ranges, with source or destination wrapping past the top of memory, and with forward-overlapping ranges, which expose any parallel or reversed copy. Writes and colour loads offered mid-copy are then checked to have changed nothing.

// File: rtl/vram_blit_engine.sv
module vram_blit_engine #(
  parameter int AW         = 17,
  parameter int COPY_WORDS = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [1:0]    bus_sel,
  input  logic [AW-1:0] bus_off,
  input  logic [31:0]   bus_data,
  input  logic [3:0]    bus_be,
  input  logic          fill_wr,
  input  logic [31:0]   fill_data,
  output logic          stall,
  output logic [AW-1:0] mem_addr,
  output logic          mem_re,
  output logic          mem_we,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata
);
  localparam int CW = (COPY_WORDS > 1) ? $clog2(COPY_WORDS) : 1;
  localparam logic [CW-1:0] LAST = CW'(COPY_WORDS - 1);

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_RD, S_WR} st_t;

  st_t           st;
  logic [31:0]   fill_q;
  logic [AW-1:0] src_q, dst_q, base_q;
  logic [15:0]   mask_q;
  logic [CW-1:0] idx_q;
  logic [1:0]    grp_q;

  wire idle = (st == S_IDLE);
  wire acc  = bus_wr & idle;
  assign stall = ~idle;

  wire [31:0] lane_m = {{8{bus_be[3]}}, {8{bus_be[2]}}, {8{bus_be[1]}}, {8{bus_be[0]}}};
  wire [31:0] fill_m = bus_data & lane_m & 32'h0F0F_0F0F;

  logic [3:0] keep_be;
  for (genvar j = 0; j < 4; j++) begin : g_lane
    assign keep_be[j] = bus_be[j] & (|bus_data[8*j +: 8]);
  end

  wire [3:0]    grp_be  = mask_q[4*grp_q +: 4];
  wire [AW-1:0] idx_ext = AW'(idx_q);

  always_comb begin
    mem_addr  = '0;
    mem_re    = 1'b0;
    mem_we    = 1'b0;
    mem_be    = 4'h0;
    mem_wdata = fill_q;
    case (st)
      S_IDLE: if (bus_wr && bus_sel == 2'd0 && |keep_be) begin
        mem_we    = 1'b1;
        mem_be    = keep_be;
        mem_addr  = bus_off;
        mem_wdata = bus_data;
      end
      S_FILL: begin
        mem_we   = |grp_be;
        mem_be   = grp_be;
        mem_addr = base_q + AW'(grp_q);
      end
      S_RD: begin
        mem_re   = 1'b1;
        mem_addr = src_q + idx_ext;
      end
      S_WR: begin
        mem_we    = 1'b1;
        mem_be    = 4'hF;
        mem_addr  = dst_q + idx_ext;
        mem_wdata = mem_rdata;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      fill_q <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      base_q <= '0;
      mask_q <= '0;
      idx_q  <= '0;
      grp_q  <= '0;
    end else begin
      if (fill_wr && idle) fill_q <= fill_data;
      case (st)
        S_IDLE: if (acc) begin
          case (bus_sel)
            2'd1: begin
              st     <= S_FILL;
              base_q <= {bus_off[AW-1:2], 2'b00};
              mask_q <= {fill_m[27:24], fill_m[19:16], fill_m[11:8], fill_m[3:0]};
              grp_q  <= '0;
            end
            2'd2: src_q <= bus_off;
            2'd3: begin
              st    <= S_RD;
              dst_q <= bus_off;
              idx_q <= '0;
            end
            default: ;
          endcase
        end
        S_FILL: begin
          grp_q <= grp_q + 2'd1;
          if (grp_q == 2'd3) st <= S_IDLE;
        end
        S_RD: st <= S_WR;
        S_WR: begin
          idx_q <= idx_q + 1'b1;
          st    <= (idx_q == LAST) ? S_IDLE : S_RD;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module vram_blit_engine_chk #(
  parameter int AW         = 17,
  parameter int COPY_WORDS = 256
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [1:0]    bus_sel,
  input logic [31:0]   bus_data,
  input logic [3:0]    bus_be,
  input logic          stall,
  input logic          mem_re,
  input logic          mem_we,
  input logic [3:0]    mem_be
);
  logic [31:0] run_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)     run_cnt <= '0;
    else if (stall) run_cnt <= run_cnt + 32'd1;
    else            run_cnt <= '0;
  end

  // R7
  no_rd_wr_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));

  // R7
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> (mem_we && mem_be == 4'hF));

  // R7
  run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (run_cnt < 32'(2 * COPY_WORDS)));

  // R8
  run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall) |-> (run_cnt == 32'd4 || run_cnt == 32'(2 * COPY_WORDS)));

  // R6
  copy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && bus_wr && bus_sel == 2'd3) |=> (stall && mem_re));

  // R5
  ptr_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && bus_wr && bus_sel == 2'd2) |-> (!mem_we && !mem_re));

  // R1
  zero_byte_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && bus_wr && bus_sel == 2'd0 && mem_we) |->
      ((mem_be & ~bus_be) == 4'h0 &&
       (!mem_be[0] || bus_data[7:0]   != 8'h0) &&
       (!mem_be[1] || bus_data[15:8]  != 8'h0) &&
       (!mem_be[2] || bus_data[23:16] != 8'h0) &&
       (!mem_be[3] || bus_data[31:24] != 8'h0)));

  // R10
  idle_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !bus_wr) |-> (!mem_we && !mem_re));
endmodule

bind vram_blit_engine vram_blit_engine_chk #(.AW(AW), .COPY_WORDS(COPY_WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel), .bus_data(bus_data),
  .bus_be(bus_be), .stall(stall), .mem_re(mem_re), .mem_we(mem_we), .mem_be(mem_be)
);

// File: tb/sim_vram_blit_engine.sv
module sim_vram_blit_engine;
  localparam int AW = 8;
  localparam int N  = 16;
  localparam int D  = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, fill_wr = 1'b0;
  logic [1:0] bus_sel = '0;
  logic [AW-1:0] bus_off = '0;
  logic [31:0] bus_data = '0, fill_data = '0;
  logic [3:0] bus_be = '0;
  logic stall, mem_re, mem_we;
  logic [AW-1:0] mem_addr;
  logic [3:0] mem_be;
  logic [31:0] mem_wdata, mem_rdata;

  always #5 clk = ~clk;

  vram_blit_engine #(.AW(AW), .COPY_WORDS(N)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel), .bus_off(bus_off),
    .bus_data(bus_data), .bus_be(bus_be), .fill_wr(fill_wr), .fill_data(fill_data),
    .stall(stall), .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  function automatic logic [31:0] pat(input int i);
    return 32'h9E37_79B9 * (i + 1) ^ 32'h5A5A_0000;
  endfunction

  logic [31:0] ram [D];
  logic [31:0] mdl [D];
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < D; i++) ram[i] <= pat(i);
      mem_rdata <= '0;
    end else begin
      if (mem_re) mem_rdata <= ram[mem_addr];
      if (mem_we)
        for (int j = 0; j < 4; j++)
          if (mem_be[j]) ram[mem_addr][8*j +: 8] <= mem_wdata[8*j +: 8];
    end
  end

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cmp_all(input string req);
    int bad = -1;
    for (int i = 0; i < D; i++) if (bad < 0 && ram[i] !== mdl[i]) bad = i;
    if (bad < 0) chk(1'b1, req, 0, 0);
    else chk(1'b0, req, ram[bad], mdl[bad]);
  endtask

  task automatic issue(input logic [1:0] s, input logic [AW-1:0] o, input logic [31:0] d,
                       input logic [3:0] b, output int busy);
    @(negedge clk);
    bus_sel = s; bus_off = o; bus_data = d; bus_be = b; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    busy = 0;
    while (stall) begin busy++; @(negedge clk); end
  endtask

  task automatic load_fill(input logic [31:0] v);
    @(negedge clk); fill_data = v; fill_wr = 1'b1;
    @(negedge clk); fill_wr = 1'b0;
  endtask

  logic [31:0] fill_m;
  logic [AW-1:0] src_m;

  task automatic m_fill(input logic [AW-1:0] o, input logic [31:0] d, input logic [3:0] b);
    logic [31:0] m;
    m = d & 32'h0F0F_0F0F;
    for (int j = 0; j < 4; j++) if (!b[j]) m[8*j +: 8] = 8'h0;
    for (int k = 0; k < 4; k++)
      for (int j = 0; j < 4; j++)
        if (m[8*k + j]) mdl[((o & ~AW'(3)) + k) % D][8*j +: 8] = fill_m[8*j +: 8];
  endtask

  task automatic m_copy(input logic [AW-1:0] dst);
    for (int i = 0; i < N; i++) mdl[(dst + i) % D] = mdl[(src_m + i) % D];
  endtask

  initial begin
    int busy;
    logic [31:0] d;
    for (int i = 0; i < D; i++) mdl[i] = pat(i);
    fill_m = '0; src_m = '0;
    repeat (3) @(negedge clk);
    // R10
    chk(stall == 1'b0 && mem_we == 1'b0 && mem_re == 1'b0, "R10 reset outputs",
        {29'd0, stall, mem_we, mem_re}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    cmp_all("R10 memory untouched after reset");

    // R10: fill colour and source pointer reset to zero
    issue(2'd1, 8'd41, 32'h0F0F_0F0F, 4'hF, busy);
    m_fill(8'd41, 32'h0F0F_0F0F, 4'hF);
    cmp_all("R10 zero fill colour");
    issue(2'd3, 8'd200, 32'h0, 4'hF, busy);
    m_copy(8'd200);
    cmp_all("R10 zero source pointer");

    // R1 sweep: every zero-byte pattern against every bus mask
    for (int z = 0; z < 16; z++)
      for (int b = 0; b < 16; b++) begin
        logic [AW-1:0] a;
        a = AW'(z * 16 + b);
        for (int j = 0; j < 4; j++) d[8*j +: 8] = z[j] ? 8'h00 : 8'(8'h11 * (j + 1) + z + b);
        issue(2'd0, a, d, 4'(b), busy);
        for (int j = 0; j < 4; j++) if (b[j] && d[8*j +: 8] != 8'h0) mdl[a][8*j +: 8] = d[8*j +: 8];
        chk(ram[a] === mdl[a] && busy == 0, "R1 masked store", ram[a], mdl[a]);
      end

    // R2 R3 R4 R8 sweep over offsets, nibble patterns and bus masks
    for (int i = 0; i < 64; i++) begin
      if (i % 8 == 0) begin
        load_fill(32'hC0DE_0000 + 32'(i * 32'h0101_0101));
        fill_m = 32'hC0DE_0000 + 32'(i * 32'h0101_0101);
      end
      d = {4'hA, 4'(i * 7), 4'h5, 4'(i * 3 + 1), 4'hF, 4'(i), 4'h3, 4'(i * 11 + 5)};
      issue(2'd1, AW'(i * 5 + 1), d, (i < 32) ? 4'hF : 4'(i), busy);
      m_fill(AW'(i * 5 + 1), d, (i < 32) ? 4'hF : 4'(i));
      cmp_all("R3 group fill");
      chk(busy == 4, "R8 fill stall length", busy, 4);
    end
    load_fill(32'h1234_5678);
    fill_m = 32'h1234_5678;
    issue(2'd1, 8'd255, 32'hFF0F_FF0F, 4'hF, busy);
    m_fill(8'd255, 32'hFF0F_FF0F, 4'hF);
    chk(ram[252] === 32'h1234_5678 && ram[255] === 32'h1234_5678, "R2 aligned full fill",
        ram[252], 32'h1234_5678);
    cmp_all("R4 fill colour held");

    // R5 R6 R7 copies
    begin
      int srcs [5] = '{10, 250, 3, 20, 40};
      int dsts [5] = '{100, 5, 248, 24, 36};
      for (int c = 0; c < 5; c++) begin
        issue(2'd2, AW'(srcs[c]), 32'hFFFF_FFFF, 4'hF, busy);
        src_m = AW'(srcs[c]);
        cmp_all("R5 pointer store no access");
        issue(2'd3, AW'(dsts[c]), 32'h0, 4'hF, busy);
        m_copy(AW'(dsts[c]));
        cmp_all("R6 block copy");
        chk(busy == 2 * N, "R7 copy stall length", busy, 2 * N);
      end
    end

    // R9: writes and loads during a copy are dropped
    src_m = 8'd60;
    issue(2'd2, 8'd60, 32'h0, 4'hF, busy);
    @(negedge clk);
    bus_sel = 2'd3; bus_off = 8'd120; bus_wr = 1'b1;
    @(negedge clk);
    bus_sel = 2'd0; bus_off = 8'd7; bus_data = 32'hAAAA_AAAA; bus_be = 4'hF;
    fill_data = 32'h5555_5555; fill_wr = 1'b1;
    @(negedge clk);
    bus_sel = 2'd2; bus_off = 8'd90;
    @(negedge clk);
    bus_sel = 2'd1; bus_off = 8'd8; bus_data = 32'h0F0F_0F0F;
    @(negedge clk);
    bus_wr = 1'b0; fill_wr = 1'b0;
    while (stall) @(negedge clk);
    m_copy(8'd120);
    cmp_all("R9 stores dropped while busy");
    issue(2'd1, 8'd180, 32'h0F0F_0F0F, 4'hF, busy);
    m_fill(8'd180, 32'h0F0F_0F0F, 4'hF);
    cmp_all("R9 fill colour kept while busy");
    issue(2'd3, 8'd140, 32'h0, 4'hF, busy);
    m_copy(8'd140);
    cmp_all("R9 source pointer kept while busy");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule